// File: doc/BRIEF.md
# Activity-Flag STDP Programming Sequencer

This block drives on-chip learning for a crossbar of memristive synapses between a layer of presynaptic inputs and a layer of postsynaptic neurons. It keeps one sticky activity bit per input instead of a timer per input. An input event sets its bit and starts an inference pulse request. When a neuron fires during training, the block walks every synapse of that neuron in ascending input order. For each synapse it sends one fixed-shape command on a serial stream: potentiate if the input was active since the previous walk, depress otherwise. The potentiation window therefore runs from one postsynaptic event to the next, with no graded timing. Each walk clears the activity bits as it starts. Decisions come from a copy of the bits taken at that moment.

Fires that arrive during a walk wait in a small queue. An initialization walk, started from a pin, covers every neuron and drives the even-numbered inputs of each to full conductance before learning begins. It uses the same command path. Pulse lengths are parameters counted in clock cycles.

Top module: `stdp_seq`

## Requirements
- R1: An input event with `in_evt_valid` high and an address below N_IN marks that input active. The next training walk issues potentiation (`cmd_pot`=1) for it.
- R2: A training walk for neuron k issues exactly N_IN commands with `cmd_out_idx`=k and `cmd_in_idx` running 0 to N_IN-1 in order. `cmd_pot` is 1 when the input is active and 0 when it is not. `cmd_init` is 0 throughout.
- R3: Starting a walk clears every activity bit. A later walk with no new events issues only depression commands.
- R4: With `cmd_ready` held high, the edges that accept consecutive commands of one walk are PROG_CYC+1 cycles apart. `cmd_valid` stays low for the PROG_CYC cycles after each acceptance.
- R5: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay unchanged and `cmd_valid` stays high.
- R6: An event that arrives during a walk, or in the cycle the walk starts, does not change that walk's decisions. It counts for the next walk.
- R7: A fire that arrives while a walk is busy is queued in a FIFO of FIFO_DEPTH entries (default 2). Queued walks run in arrival order.
- R8: A fire that finds the queue full is dropped, and `fire_ovf` rises and stays high until reset.
- R9: `sample_clr` clears every activity bit. It takes priority over an event in the same cycle.
- R10: While `train_en` is low, `post_fire_valid` starts no walk and leaves the activity bits unchanged.
- R11: A pulse on `init_start` runs one walk per neuron, from 0 to N_OUT-1. Each walk issues N_IN commands with `cmd_init`=1 and `cmd_pot`=1 exactly on even input indices. The activity bits are ignored and cleared.
- R12: Each input event raises `inf_pulse` for exactly INF_CYC cycles, starting the cycle after the event is sampled. `inf_addr` gives that event's address, and a new event restarts the count.
- R13: After reset, `cmd_valid`, `busy`, `fire_ovf` and `inf_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| train_en | input | 1 | Enables fire-driven learning walks |
| init_start | input | 1 | Requests the half-to-maximum initialization walk |
| sample_clr | input | 1 | Clears all activity bits at a sample boundary |
| in_evt_valid | input | 1 | Input event strobe |
| in_evt_addr | input | $clog2(N_IN) | Input event address |
| post_fire_valid | input | 1 | Postsynaptic fire strobe |
| post_fire_idx | input | $clog2(N_OUT) | Index of the firing neuron |
| inf_pulse | output | 1 | Inference pulse request, INF_CYC cycles long |
| inf_addr | output | $clog2(N_IN) | Input addressed by the inference pulse |
| cmd_valid | output | 1 | Programming command valid |
| cmd_ready | input | 1 | Programming command accepted |
| cmd_in_idx | output | $clog2(N_IN) | Presynaptic index of the command |
| cmd_out_idx | output | $clog2(N_OUT) | Postsynaptic index of the command |
| cmd_pot | output | 1 | 1 = potentiate, 0 = depress |
| cmd_init | output | 1 | Command belongs to the initialization walk |
| busy | output | 1 | A walk is in progress |
| fire_ovf | output | 1 | Sticky: a fire was lost to a full queue |

## Verification
The hardest state to reach is a full fire queue with a walk in flight. It needs fires closely spaced so that one is taken by the walker and two more fill the queue before any walk ends. The bench fires four neurons on four consecutive cycles, which leaves the fourth with no room. It then checks that exactly three walks follow, in order. A similar timing problem arises for an input event that lands in the middle of a walk. The bench watches the command log and injects the event once two commands have been accepted. It then confirms that the bit shows up only in the following walk.

// File: rtl/stdp_seq_pkg.sv
package stdp_seq_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_HOLD  = 2'd2
  } wk_state_t;
endpackage

// File: rtl/stdp_act_flags.sv
// Sticky per-input activity bits plus the copy that a walk decides from.
module stdp_act_flags #(
  parameter int N_IN = 784,
  localparam int IN_W = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_valid,
  input  logic [IN_W-1:0] evt_addr,
  input  logic            sample_clr,
  input  logic            snap_load,
  output logic [N_IN-1:0] snap
);
  logic [N_IN-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (snap_load || sample_clr) flags_d = '0;
    for (int i = 0; i < N_IN; i++)
      if (evt_valid && !sample_clr && (evt_addr == IN_W'(i))) flags_d[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         snap <= '0;
    else if (snap_load) snap <= flags_q;

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !sample_clr |=> flags_q[$past(evt_addr)]);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_clr |=> (flags_q == '0));
endmodule

// File: rtl/stdp_fire_fifo.sv
// Small queue of pending neuron indices with a sticky loss flag.
module stdp_fire_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && ((cnt_q != CW'(DEPTH)) || pop_ok);
  assign dout    = mem[rd_q];

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wr_q] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; ovf <= 1'b0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      if (pop_ok)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      cnt_q <= cnt_d;
      if (push && !push_ok) ovf <= 1'b1;
    end

  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/stdp_walker.sv
// Walks one neuron's synapses (or every neuron's, in init mode) and emits commands.
module stdp_walker
  import stdp_seq_pkg::*;
#(
  parameter int N_IN     = 784,
  parameter int N_OUT    = 100,
  parameter int PROG_CYC = 50,
  localparam int IN_W  = $clog2(N_IN),
  localparam int OUT_W = $clog2(N_OUT),
  localparam int HC_W  = $clog2(PROG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             q_empty,
  input  logic [OUT_W-1:0] q_idx,
  input  logic [N_IN-1:0]  snap,
  input  logic             cmd_ready,
  output logic             q_pop,
  output logic             snap_load,
  output logic             init_ack,
  output logic             cmd_valid,
  output logic [IN_W-1:0]  cmd_in_idx,
  output logic [OUT_W-1:0] cmd_out_idx,
  output logic             cmd_pot,
  output logic             cmd_init,
  output logic             busy
);
  wk_state_t        st_q, st_d;
  logic [IN_W-1:0]  in_q, in_d;
  logic [OUT_W-1:0] out_q, out_d;
  logic             init_q, init_d;
  logic [HC_W-1:0]  hc_q, hc_d;

  always_comb begin
    st_d = st_q; in_d = in_q; out_d = out_q; init_d = init_q; hc_d = hc_q;
    q_pop = 1'b0; snap_load = 1'b0; init_ack = 1'b0;
    unique case (st_q)
      WK_IDLE: begin
        if (init_req) begin
          init_ack = 1'b1; snap_load = 1'b1;
          init_d = 1'b1; out_d = '0; in_d = '0; st_d = WK_ISSUE;
        end else if (!q_empty) begin
          q_pop = 1'b1; snap_load = 1'b1;
          init_d = 1'b0; out_d = q_idx; in_d = '0; st_d = WK_ISSUE;
        end
      end
      WK_ISSUE: begin
        if (cmd_ready) begin
          hc_d = '0; st_d = WK_HOLD;
        end
      end
      WK_HOLD: begin
        if (hc_q == HC_W'(PROG_CYC - 1)) begin
          if (in_q == IN_W'(N_IN - 1)) begin
            if (init_q && (out_q != OUT_W'(N_OUT - 1))) begin
              out_d = out_q + OUT_W'(1); in_d = '0; st_d = WK_ISSUE;
            end else begin
              st_d = WK_IDLE;
            end
          end else begin
            in_d = in_q + IN_W'(1); st_d = WK_ISSUE;
          end
        end else begin
          hc_d = hc_q + HC_W'(1);
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= WK_IDLE; in_q <= '0; out_q <= '0; init_q <= 1'b0; hc_q <= '0;
    end else begin
      st_q <= st_d; in_q <= in_d; out_q <= out_d; init_q <= init_d; hc_q <= hc_d;
    end

  assign cmd_valid   = (st_q == WK_ISSUE);
  assign cmd_in_idx  = in_q;
  assign cmd_out_idx = out_q;
  assign cmd_init    = init_q;
  assign cmd_pot     = init_q ? ~in_q[0] : snap[in_q];
  assign busy        = (st_q != WK_IDLE);

  assert_cmd_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_in_idx)
      && $stable(cmd_out_idx) && $stable(cmd_pot) && $stable(cmd_init));
  assert_hold_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);
endmodule

// File: rtl/stdp_seq.sv
// Top: reset release, fire gating, init request latch, inference pulse timer.
module stdp_seq #(
  parameter int N_IN        = 784,
  parameter int N_OUT       = 100,
  parameter int PROG_CYC    = 50,
  parameter int INF_CYC     = 1000,
  parameter int FIFO_DEPTH  = 2,
  localparam int IN_W  = $clog2(N_IN),
  localparam int OUT_W = $clog2(N_OUT),
  localparam int IC_W  = $clog2(INF_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_en,
  input  logic             init_start,
  input  logic             sample_clr,
  input  logic             in_evt_valid,
  input  logic [IN_W-1:0]  in_evt_addr,
  input  logic             post_fire_valid,
  input  logic [OUT_W-1:0] post_fire_idx,
  output logic             inf_pulse,
  output logic [IN_W-1:0]  inf_addr,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [IN_W-1:0]  cmd_in_idx,
  output logic [OUT_W-1:0] cmd_out_idx,
  output logic             cmd_pot,
  output logic             cmd_init,
  output logic             busy,
  output logic             fire_ovf
);
  logic rst_q1, rst_s_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rst_q1 <= 1'b0; rst_s_n <= 1'b0; end
    else        begin rst_q1 <= 1'b1; rst_s_n <= rst_q1; end

  logic             init_pend_q, init_ack, q_pop, q_empty, snap_load;
  logic [OUT_W-1:0] q_idx;
  logic [N_IN-1:0]  snap;
  logic [IC_W-1:0]  icnt_q;

  always_ff @(posedge clk or negedge rst_s_n)
    if (!rst_s_n)        init_pend_q <= 1'b0;
    else if (init_start) init_pend_q <= 1'b1;
    else if (init_ack)   init_pend_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_s_n)
    if (!rst_s_n)          icnt_q <= '0;
    else if (in_evt_valid) icnt_q <= IC_W'(INF_CYC);
    else if (inf_pulse)    icnt_q <= icnt_q - IC_W'(1);

  always_ff @(posedge clk or negedge rst_s_n)
    if (!rst_s_n)          inf_addr <= '0;
    else if (in_evt_valid) inf_addr <= in_evt_addr;

  assign inf_pulse = (icnt_q != '0);

  stdp_act_flags #(.N_IN(N_IN)) u_flags (
    .clk, .rst_n(rst_s_n), .evt_valid(in_evt_valid), .evt_addr(in_evt_addr),
    .sample_clr, .snap_load, .snap
  );

  stdp_fire_fifo #(.W(OUT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n(rst_s_n), .push(post_fire_valid && train_en), .din(post_fire_idx),
    .pop(q_pop), .dout(q_idx), .empty(q_empty), .ovf(fire_ovf)
  );

  stdp_walker #(.N_IN(N_IN), .N_OUT(N_OUT), .PROG_CYC(PROG_CYC)) u_walk (
    .clk, .rst_n(rst_s_n), .init_req(init_pend_q), .q_empty, .q_idx, .snap,
    .cmd_ready, .q_pop, .snap_load, .init_ack, .cmd_valid, .cmd_in_idx,
    .cmd_out_idx, .cmd_pot, .cmd_init, .busy
  );

  assert_inf_start_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_evt_valid |=> inf_pulse && (inf_addr == $past(in_evt_addr)));
endmodule

// File: tb/stdp_seq_bench.sv
module stdp_seq_bench;
  localparam int N_IN = 8, N_OUT = 4, PROG_CYC = 2, INF_CYC = 3, FIFO_DEPTH = 2;
  localparam int IN_W = $clog2(N_IN), OUT_W = $clog2(N_OUT);
  localparam int NV = 5;
  // each entry: {active-input pattern, neuron}
  localparam logic [N_IN+OUT_W-1:0] VEC [NV] = '{
    {8'b1010_0101, 2'd1}, {8'b0000_0000, 2'd2}, {8'b1111_1111, 2'd3},
    {8'b0000_0001, 2'd0}, {8'b1000_0000, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic train_en = 1'b1, init_start = 1'b0, sample_clr = 1'b0;
  logic in_evt_valid = 1'b0, post_fire_valid = 1'b0, cmd_ready = 1'b1;
  logic [IN_W-1:0] in_evt_addr = '0;
  logic [OUT_W-1:0] post_fire_idx = '0;
  logic inf_pulse, cmd_valid, cmd_pot, cmd_init, busy, fire_ovf;
  logic [IN_W-1:0] inf_addr, cmd_in_idx;
  logic [OUT_W-1:0] cmd_out_idx;

  always #5 clk = ~clk;

  stdp_seq #(.N_IN(N_IN), .N_OUT(N_OUT), .PROG_CYC(PROG_CYC), .INF_CYC(INF_CYC),
             .FIFO_DEPTH(FIFO_DEPTH)) u_stdp_seq (.*);

  int n_chk = 0, n_fail = 0, n_log = 0, cyc = 0;
  int log_in [512], log_out [512], log_pot [512], log_init [512], log_cyc [512];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (rst_n && cmd_valid && cmd_ready && n_log < 512) begin
      log_in[n_log] = cmd_in_idx; log_out[n_log] = cmd_out_idx;
      log_pot[n_log] = cmd_pot; log_init[n_log] = cmd_init;
      log_cyc[n_log] = cyc; n_log++;
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic evt(input int a);
    @(negedge clk); in_evt_valid = 1'b1; in_evt_addr = IN_W'(a);
    @(negedge clk); in_evt_valid = 1'b0;
  endtask

  task automatic fire(input int k);
    @(negedge clk); post_fire_valid = 1'b1; post_fire_idx = OUT_W'(k);
    @(negedge clk); post_fire_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    int t = 0;
    while (q < 3 && t < 5000) begin
      @(negedge clk); t++;
      if (!busy) q++; else q = 0;
    end
  endtask

  // check one full training walk starting at log position b
  task automatic chk_walk(input int b, input int k, input logic [N_IN-1:0] pat,
                          input string req);
    chk(n_log - b == N_IN, req, "command count", n_log - b, N_IN);
    for (int j = 0; j < N_IN; j++) begin
      chk(log_out[b+j] == k && log_in[b+j] == j && log_pot[b+j] == int'(pat[j])
          && log_init[b+j] == 0, req, $sformatf("cmd %0d pot", j),
          log_pot[b+j], int'(pat[j]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b;
    int hi;
    logic [N_IN-1:0] pat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(!cmd_valid && !busy && !fire_ovf && !inf_pulse, "R13", "idle outputs",
        {cmd_valid, busy, fire_ovf, inf_pulse}, 0);

    // R1 R2 R3 table-driven walks; entry 1 has no events, showing R3 clearing
    for (int v = 0; v < NV; v++) begin
      pat = VEC[v][N_IN+OUT_W-1:OUT_W];
      for (int i = 0; i < N_IN; i++) if (pat[i]) evt(i);
      b = n_log;
      fire(int'(VEC[v][OUT_W-1:0]));
      wait_idle();
      chk_walk(b, int'(VEC[v][OUT_W-1:0]), pat, v == 1 ? "R3" : "R2");
      if (v == 0)
        for (int j = 0; j < N_IN - 1; j++)
          chk(log_cyc[b+j+1] - log_cyc[b+j] == PROG_CYC + 1, "R4", "command spacing",
              log_cyc[b+j+1] - log_cyc[b+j], PROG_CYC + 1);
    end

    // R5 backpressure
    cmd_ready = 1'b0;
    evt(2);
    b = n_log;
    fire(3);
    repeat (6) @(negedge clk);
    chk(cmd_valid && cmd_in_idx == 0 && cmd_out_idx == 3 && cmd_pot == 1'b0,
        "R5", "held command", {cmd_valid, cmd_in_idx}, 8);
    chk(n_log == b, "R5", "no acceptance while stalled", n_log - b, 0);
    cmd_ready = 1'b1;
    wait_idle();
    chk_walk(b, 3, 8'b0000_0100, "R5");

    // R6 event during a walk lands in the next walk
    b = n_log;
    fire(1);
    while (n_log < b + 2) @(negedge clk);
    evt(5);
    wait_idle();
    chk_walk(b, 1, 8'b0, "R6");
    b = n_log;
    fire(0);
    wait_idle();
    chk_walk(b, 0, 8'b0010_0000, "R6");

    // R9 sample clear, winning over a same-cycle event
    evt(1); evt(3);
    @(negedge clk); sample_clr = 1'b1; in_evt_valid = 1'b1; in_evt_addr = 3'd6;
    @(negedge clk); sample_clr = 1'b0; in_evt_valid = 1'b0;
    b = n_log;
    fire(2);
    wait_idle();
    chk_walk(b, 2, 8'b0, "R9");

    // R10 fires ignored when training disabled, bits kept
    evt(4);
    train_en = 1'b0;
    b = n_log;
    fire(1);
    repeat (10) @(negedge clk);
    chk(n_log == b && !busy, "R10", "commands while disabled", n_log - b, 0);
    train_en = 1'b1;
    fire(1);
    wait_idle();
    chk_walk(b, 1, 8'b0001_0000, "R10");

    // R11 initialization walk
    evt(1);
    b = n_log;
    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    wait_idle();
    chk(n_log - b == N_IN * N_OUT, "R11", "init command count", n_log - b, N_IN * N_OUT);
    for (int j = 0; j < N_IN * N_OUT; j++)
      chk(log_out[b+j] == j / N_IN && log_in[b+j] == j % N_IN && log_init[b+j] == 1
          && log_pot[b+j] == int'((j % 2) == 0), "R11", $sformatf("init cmd %0d pot", j),
          log_pot[b+j], int'((j % 2) == 0));
    b = n_log;
    fire(0);
    wait_idle();
    chk_walk(b, 0, 8'b0, "R11");

    // R12 inference pulse width and address
    repeat (5) @(negedge clk);
    chk(!inf_pulse, "R12", "pulse before event", int'(inf_pulse), 0);
    @(negedge clk); in_evt_valid = 1'b1; in_evt_addr = 3'd3;
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); in_evt_valid = 1'b0;
      if (inf_pulse) hi++;
    end
    chk(hi == INF_CYC && inf_addr == 3, "R12", "pulse cycles", hi, INF_CYC);
    b = n_log;
    fire(0);
    wait_idle();
    chk_walk(b, 0, 8'b0000_1000, "R1");

    // R7 R8 queue order and overflow
    chk(!fire_ovf, "R8", "ovf before overflow", int'(fire_ovf), 0);
    b = n_log;
    @(negedge clk); post_fire_valid = 1'b1; post_fire_idx = 2'd0;
    @(negedge clk); post_fire_idx = 2'd1;
    @(negedge clk); post_fire_idx = 2'd2;
    @(negedge clk); post_fire_idx = 2'd3;
    @(negedge clk); post_fire_valid = 1'b0;
    chk(fire_ovf, "R8", "ovf after full queue", int'(fire_ovf), 1);
    wait_idle();
    chk(n_log - b == 3 * N_IN, "R7", "queued walk commands", n_log - b, 3 * N_IN);
    for (int w = 0; w < 3; w++)
      chk(log_out[b + w*N_IN] == w && log_out[b + w*N_IN + N_IN - 1] == w, "R7",
          $sformatf("walk %0d neuron", w), log_out[b + w*N_IN], w);
    repeat (5) @(negedge clk);
    chk(fire_ovf, "R8", "ovf sticky", int'(fire_ovf), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule